// File: doc/BRIEF.md
# Transmit FCS Append with Abort

This block sits in the outgoing byte stream of an Ethernet transmitter. Bytes pass straight through from input to output while a CRC-32 is accumulated over them. At the end of each frame the block decides whether to add the four-byte frame check sequence. That decision is taken once per frame, on the first byte, from three inputs: a per-frame append request, a global disable-FCS setting and a global auto-pad setting.

A kill request can abort a frame. If the kill is present when the first byte is offered, the whole frame is consumed and nothing is emitted. If the kill arrives after some bytes have gone out, the block stops passing data. It closes the frame with a check sequence that is the bitwise inverse of the correct one, so any receiver rejects the frame. It then discards the rest of the input frame.

The output uses a valid/ready handshake. Backpressure stalls both the CRC and input acceptance.

Top module: `tx_fcs_append`

## Requirements
- R1: The appended FCS is the Ethernet CRC-32 over the bytes output in that frame (reflected polynomial 0xEDB88320, initial value all ones, final complement). It is sent least-significant byte first, so the nine ASCII bytes "123456789" are followed by 26h 39h F4h CBh.
- R2: With fcs_req_i at 1 on the first byte, the FCS is appended whatever fcs_dis_i is.
- R3: With fcs_req_i at 0 and auto_pad_i at 0, the FCS is appended when fcs_dis_i is 0 and omitted when fcs_dis_i is 1.
- R4: With auto_pad_i at 1 on the first byte, the FCS is always appended, and fcs_req_i has no effect.
- R5: fcs_req_i, fcs_dis_i and auto_pad_i are sampled only with the first byte of a frame. Changes on later bytes of the same frame do not alter that frame's output.
- R6: out_last_o is 1 only on the final output byte of a frame. That is the last FCS byte when an FCS follows, and the last data byte otherwise.
- R7: If kill_i is 1 while a frame is open and at least one of its bytes has been output, no further data bytes are output. The frame ends with four bytes equal to the inverse of the correct FCS over the bytes already sent, with out_last_o on the fourth. This happens whatever the append decision was. Remaining input bytes up to and including in_last_i are accepted and discarded.
- R8: If kill_i is 1 when the first byte of a frame is offered, no output byte is produced for that frame, and all of its input bytes are accepted.
- R9: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0 and the output byte is held unchanged until it is taken.
- R10: out_first_o is 1 on the first output byte of a frame and on no other byte.
- R11: An input byte with in_first_i at 0 while no frame is open is accepted and produces no output.
- R12: After reset, with no input offered, out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_pad_i | input | 1 | Global auto-pad setting; forces FCS append |
| fcs_dis_i | input | 1 | Global FCS disable, used when no per-frame request |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted this cycle |
| in_first_i | input | 1 | Input byte is the first of its frame |
| in_last_i | input | 1 | Input byte is the last of its frame |
| in_data_i | input | 8 | Input byte |
| fcs_req_i | input | 1 | Per-frame append request, sampled on the first byte |
| kill_i | input | 1 | Abort request for the current frame |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream takes the output byte |
| out_first_o | output | 1 | Output byte is the first of its frame |
| out_last_o | output | 1 | Output byte is the last of its frame |
| out_data_o | output | 8 | Output byte |

## Verification
The abort and the data path collide when kill_i rises in the same cycle that a data byte is offered. That byte may even be stalled by out_ready_i at 0. The bench raises the kill together with byte k of frames of several lengths, both with the output ready and under a repeating stall pattern. It judges the outcome by three things: exactly k data bytes appear, the four trailing bytes are the complement of a CRC the bench computes over those k bytes, and the rest of the input is drained without output. The case k = 0 is also driven and must give an empty output frame.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
  localparam int unsigned IDX_W     = $clog2(FCS_BYTES);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PASS,
    ST_FCS,
    ST_DROP
  } st_e;

  // one byte of reflected CRC, LSB of data first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < BYTE_W; b++) begin
      fb = r[0] ^ d[b];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc
  import tx_fcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              init_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = init_i ? CRC_INIT : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_INIT;
    else if (en_i) crc_q <= crc_step(base, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tx_fcs_policy.sv
module tx_fcs_policy (
  input  logic req_i,
  input  logic dis_i,
  input  logic pad_i,
  output logic append_o
);
  // fixed priority: auto-pad, then per-frame request, then global disable
  always_comb begin
    if (pad_i)      append_o = 1'b1;
    else if (req_i) append_o = 1'b1;
    else            append_o = ~dis_i;
  end
endmodule

// File: rtl/tx_fcs_emit.sv
module tx_fcs_emit
  import tx_fcs_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic              bad_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [CRC_W-1:0]  word;
  logic [BYTE_W-1:0] lanes [FCS_BYTES];

  // good FCS is the complemented register; a killed frame sends it uncomplemented
  assign word = bad_i ? crc_i : ~crc_i;

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_lane
    assign lanes[g] = word[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lanes[idx_i];
endmodule

// File: rtl/tx_fcs_append.sv
module tx_fcs_append
  import tx_fcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_pad_i,
  input  logic              fcs_dis_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_first_i,
  input  logic              in_last_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              fcs_req_i,
  input  logic              kill_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_first_o,
  output logic              out_last_o,
  output logic [BYTE_W-1:0] out_data_o
);
  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             app_q, app_d;
  logic             bad_q, bad_d;
  logic             drop_q, drop_d;
  logic             app_now;
  logic             crc_en, crc_init;
  logic [CRC_W-1:0] crc;
  logic [BYTE_W-1:0] fcs_byte;
  logic             fcs_end;

  tx_fcs_policy i_policy (
    .req_i    (fcs_req_i),
    .dis_i    (fcs_dis_i),
    .pad_i    (auto_pad_i),
    .append_o (app_now)
  );

  tx_fcs_crc i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (crc_en),
    .init_i (crc_init),
    .data_i (in_data_i),
    .crc_o  (crc)
  );

  tx_fcs_emit i_emit (
    .crc_i  (crc),
    .bad_i  (bad_q),
    .idx_i  (idx_q),
    .byte_o (fcs_byte)
  );

  assign fcs_end = (idx_q == IDX_W'(FCS_BYTES - 1));

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    app_d       = app_q;
    bad_d       = bad_q;
    drop_d      = drop_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_first_o = 1'b0;
    out_last_o  = 1'b0;
    out_data_o  = in_data_i;
    crc_en      = 1'b0;
    crc_init    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid_i) begin
          if (!in_first_i) begin
            in_ready_o = 1'b1;
          end else if (kill_i) begin
            in_ready_o = 1'b1;
            if (!in_last_i) st_d = ST_DROP;
          end else begin
            out_valid_o = 1'b1;
            out_first_o = 1'b1;
            out_last_o  = in_last_i & ~app_now;
            in_ready_o  = out_ready_i;
            if (out_ready_i) begin
              crc_en   = 1'b1;
              crc_init = 1'b1;
              app_d    = app_now;
              bad_d    = 1'b0;
              drop_d   = 1'b0;
              if (in_last_i) st_d = app_now ? ST_FCS : ST_IDLE;
              else           st_d = ST_PASS;
            end
          end
        end
      end
      ST_PASS: begin
        if (kill_i) begin
          st_d   = ST_FCS;
          bad_d  = 1'b1;
          drop_d = 1'b1;
        end else if (in_valid_i) begin
          out_valid_o = 1'b1;
          out_last_o  = in_last_i & ~app_q;
          in_ready_o  = out_ready_i;
          if (out_ready_i) begin
            crc_en = 1'b1;
            if (in_last_i) st_d = app_q ? ST_FCS : ST_IDLE;
          end
        end
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        out_data_o  = fcs_byte;
        out_last_o  = fcs_end;
        if (out_ready_i) begin
          idx_d = idx_q + IDX_W'(1);
          if (fcs_end) begin
            idx_d = '0;
            st_d  = drop_q ? ST_DROP : ST_IDLE;
          end
        end
      end
      ST_DROP: begin
        in_ready_o = 1'b1;
        if (in_valid_i && in_last_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      app_q  <= 1'b0;
      bad_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      app_q  <= app_d;
      bad_q  <= bad_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/tx_fcs_append_chk.sv
module tx_fcs_append_chk
  import tx_fcs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              kill_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_first_o,
  input logic              out_last_o,
  input logic [BYTE_W-1:0] out_data_o,
  input st_e               st_q,
  input logic              bad_q
);
  p_stall_blocks_input_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_fcs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FCS && out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  p_kill_goes_bad_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PASS && kill_i) |=> (st_q == ST_FCS && bad_q));

  p_fcs_no_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FCS) |-> !in_ready_o);

  p_drop_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DROP) |-> !out_valid_o);

  p_no_first_midframe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_last_o) |=> !(out_valid_o && out_first_o));

  p_last_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> (st_q == ST_IDLE || st_q == ST_DROP));
endmodule

bind tx_fcs_append tx_fcs_append_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .kill_i      (kill_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_first_o (out_first_o),
  .out_last_o  (out_last_o),
  .out_data_o  (out_data_o),
  .st_q        (st_q),
  .bad_q       (bad_q)
);

// File: tb/test_tx_fcs_append.sv
module test_tx_fcs_append;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       auto_pad, fcs_dis, fcs_req, kill;
  logic       in_valid, in_first, in_last;
  logic [7:0] in_data;
  logic       in_ready_o;
  logic       out_valid_o, out_first_o, out_last_o;
  logic [7:0] out_data_o;
  logic       out_ready;

  int  n_total = 0;
  int  n_fail  = 0;
  int  cyc     = 0;
  bit  stall_mode = 0;
  bit  hold_low   = 0;

  logic [7:0] fbuf  [64];
  logic [7:0] got_d [128];
  bit         got_f [128];
  bit         got_l [128];
  int         got_n = 0;

  tx_fcs_append i_tx_fcs_append (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .auto_pad_i  (auto_pad),
    .fcs_dis_i   (fcs_dis),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready_o),
    .in_first_i  (in_first),
    .in_last_i   (in_last),
    .in_data_i   (in_data),
    .fcs_req_i   (fcs_req),
    .kill_i      (kill),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready),
    .out_first_o (out_first_o),
    .out_last_o  (out_last_o),
    .out_data_o  (out_data_o)
  );

  typedef struct packed {
    int len;
    int kill_at;
    bit req;
    bit dis;
    bit pad;
    bit stall;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6, -1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5, -1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{7, -1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4, -1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1, -1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1, -1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8,  3, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5,  1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{6,  0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{9, -1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{6,  4, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1,  0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  always @(negedge clk) begin
    cyc++;
    out_ready = hold_low ? 1'b0 : (stall_mode ? ((cyc % 3) != 0) : 1'b1);
  end

  // monitor one ns before each rising edge
  initial forever begin
    @(negedge clk);
    #4;
    if (rst_n && out_valid_o && out_ready && got_n < 128) begin
      got_d[got_n] = out_data_o;
      got_f[got_n] = out_first_o;
      got_l[got_n] = out_last_o;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ fbuf[i][b]) != 0) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return c;
  endfunction

  task automatic send_frame(input int len, input int kill_at,
                            input bit req, input bit dis, input bit pad);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fbuf[i];
      in_first = (i == 0);
      in_last  = (i == len - 1);
      // R5: later bytes carry the opposite control values
      fcs_req  = (i == 0) ? req : ~req;
      fcs_dis  = (i == 0) ? dis : ~dis;
      auto_pad = (i == 0) ? pad : ~pad;
      kill     = (kill_at >= 0 && i >= kill_at);
      forever begin
        #4;
        if (in_ready_o) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    kill     = 1'b0;
  endtask

  task automatic run_frame(input string tag, input int len, input int kill_at,
                           input bit req, input bit dis, input bit pad);
    logic [7:0]  exp_d [128];
    logic [31:0] raw;
    int n_exp, sent, bad;
    bit app;
    got_n = 0;
    send_frame(len, kill_at, req, dis, pad);
    repeat (30) @(negedge clk);
    app = pad ? 1'b1 : (req ? 1'b1 : ~dis);
    if (kill_at == 0) begin
      sent = 0; n_exp = 0;
    end else if (kill_at > 0 && kill_at < len) begin
      sent = kill_at;
      raw  = ref_crc(sent);
      for (int i = 0; i < sent; i++) exp_d[i] = fbuf[i];
      for (int k = 0; k < 4; k++) exp_d[sent+k] = raw[8*k +: 8];
      n_exp = sent + 4;
    end else begin
      sent = len;
      raw  = ~ref_crc(sent);
      for (int i = 0; i < sent; i++) exp_d[i] = fbuf[i];
      n_exp = sent;
      if (app) begin
        for (int k = 0; k < 4; k++) exp_d[sent+k] = raw[8*k +: 8];
        n_exp = sent + 4;
      end
    end
    check(got_n == n_exp, tag, "output length", got_n, n_exp);
    if (got_n == n_exp) begin
      bad = 0;
      for (int i = 0; i < n_exp; i++) if (got_d[i] !== exp_d[i]) bad++;
      check(bad == 0, "R1", "byte mismatches", bad, 0);
      bad = 0;
      for (int i = 0; i < n_exp; i++) if (got_l[i] != (i == n_exp - 1)) bad++;
      check(bad == 0, "R6", "misplaced last flags", bad, 0);
      bad = 0;
      for (int i = 0; i < n_exp; i++) if (got_f[i] != (i == 0)) bad++;
      check(bad == 0, "R10", "misplaced first flags", bad, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    auto_pad = 0; fcs_dis = 0; fcs_req = 0; kill = 0;
    in_valid = 0; in_first = 0; in_last = 0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #4;
    check(out_valid_o == 1'b0, "R12", "out_valid after reset", out_valid_o, 0);

    // R1 known vector "123456789"
    for (int i = 0; i < 9; i++) fbuf[i] = 8'h31 + 8'(i);
    got_n = 0;
    send_frame(9, -1, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(got_n == 13, "R1", "known vector length", got_n, 13);
    check({got_d[9], got_d[10], got_d[11], got_d[12]} == 32'h2639F4CB,
          "R1", "known vector FCS", {got_d[9], got_d[10], got_d[11], got_d[12]}, 32'h2639F4CB);

    foreach (VECS[v]) begin
      for (int i = 0; i < VECS[v].len; i++) fbuf[i] = 8'(v * 37 + i * 11 + 5);
      if (VECS[v].kill_at == 0) tag = "R8";
      else if (VECS[v].kill_at > 0) tag = "R7";
      else if (VECS[v].stall) tag = "R9";
      else if (VECS[v].pad) tag = "R4";
      else if (VECS[v].req) tag = "R2";
      else tag = "R3";
      stall_mode = VECS[v].stall;
      run_frame(tag, VECS[v].len, VECS[v].kill_at, VECS[v].req, VECS[v].dis, VECS[v].pad);
      stall_mode = 0;
    end

    // R11 stray byte with no frame open
    got_n = 0;
    @(negedge clk);
    in_valid = 1; in_first = 0; in_last = 0; in_data = 8'h77;
    #4;
    check(in_ready_o == 1'b1, "R11", "stray byte accepted", in_ready_o, 1);
    @(negedge clk);
    in_valid = 0;
    repeat (5) @(negedge clk);
    check(got_n == 0, "R11", "stray byte output count", got_n, 0);

    // R9 held output under backpressure
    got_n = 0;
    hold_low = 1;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1; in_first = 1; in_last = 1; in_data = 8'hA5;
    fcs_req = 1; fcs_dis = 1; auto_pad = 0;
    #4;
    check(out_valid_o && !in_ready_o, "R9", "stalled valid/ready",
          {out_valid_o, in_ready_o}, 2'b10);
    @(negedge clk);
    #4;
    check(out_data_o == 8'hA5 && out_valid_o, "R9", "stalled data held", out_data_o, 8'hA5);
    hold_low = 0;
    @(negedge clk);
    #4;
    check(in_ready_o == 1'b1, "R9", "released ready", in_ready_o, 1);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    repeat (10) @(negedge clk);
    check(got_n == 5, "R9", "frame after release length", got_n, 5);
    if (got_n == 5) begin
      fbuf[0] = 8'hA5;
      check({got_d[4], got_d[3], got_d[2], got_d[1]} == ~ref_crc(1), "R2",
            "single byte FCS", {got_d[4], got_d[3], got_d[2], got_d[1]}, ~ref_crc(1));
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule